// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Register Bank

This block is the host-side register front end of a two-channel serial controller. The host sees a single 8-bit bus with a write strobe, a read strobe, a channel select and a data/control select. Data accesses go straight to the selected channel's transmit buffer on a write, or come from its receive buffer on a read. Control accesses reach one of sixteen register addresses through a per-channel pointer. Each channel's register 0 holds that pointer.

A control write to register 0 loads the pointer. The next control access on that channel uses the pointer and then sends it back to zero. Some registers exist once and are shared by both channels: the interrupt vector and the interrupt control byte. A mode bit in register 15 sends address-7 writes to an extension register, and it maps frame-status bytes onto read addresses 6 and 7. The serial engines and the frame-status FIFO are outside this block. Their status appears here only as stub inputs.

Top module: `sio_regfile_top`

## Requirements
- R1: After synchronous reset every stored register, both pointers, both transmit buffers and the shared registers are zero. `tx_wr_o` is low.
- R2: A control write while the pointer is 0 loads a new pointer. Byte bits [2:0] give the low address bits. If byte bits [5:3] equal 3'b001, address bit 3 is set. Any other code leaves address bit 3 clear.
- R3: A control read or write at a nonzero pointer acts on that address, then returns the pointer to 0. The next control access on that channel therefore targets register 0.
- R4: A data write stores the byte in the selected channel's transmit buffer (`tx_buf_o`) and pulses that channel's `tx_wr_o` bit for one cycle. A control write to address 8 does the same. A data read returns that channel's receive byte. Data accesses leave the pointer unchanged.
- R5: Each channel has its own pointer and its own copies of registers 1, 3-7 and 10-15. An access on one channel leaves the other channel's pointer and registers unchanged.
- R6: Addresses 2 (vector) and 9 (interrupt control) are single shared registers. A write through either channel updates the same storage. `int_ctl_o` shows address 9.
- R7: If bit 0 of a channel's register 15 is set, that channel's address-7 writes go to its extension register (`sync7x_o`) and register 7 stays unchanged. If the bit is clear, address-7 writes go to register 7 (`sync7_o`).
- R8: If bit 0 of register 15 is set, read addresses 6 and 7 return that channel's frame-status low and high bytes. If the bit is clear, addresses 6 and 7 alias to read addresses 2 and 3.
- R9: Read address 2 on channel A returns the stored vector unchanged. On channel B it returns the vector with bits [3:1] replaced by `vstat_i`.
- R10: Read address 3 returns `ip_i` on channel A and zero on channel B.
- R11: Read addresses 12 and 13 return the stored registers 12 and 13. Read addresses 0, 1, 10 and 15 return the channel's status inputs.
- R12: The remaining read addresses alias as follows: 4 to 0, 5 to 1, 9 to 13, 11 to 15 and 14 to 10. A control read at address 8 returns the receive byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_data | input | 1 | 1 = data access, 0 = control access |
| chan_b | input | 1 | 0 = channel A, 1 = channel B |
| wr_stb | input | 1 | Write strobe, one access per high cycle |
| rd_stb | input | 1 | Read strobe, one access per high cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational while rd_stb is high, zero otherwise |
| rx_data_i | input | 16 | Receive bytes (B in [15:8], A in [7:0]) |
| st0_i | input | 16 | Status byte for read address 0, per channel |
| st1_i | input | 16 | Receive-error status for read address 1, per channel |
| st10_i | input | 16 | Status for read address 10, per channel |
| st15_i | input | 16 | Status for read address 15, per channel |
| ip_i | input | 8 | Interrupt pending bits |
| vstat_i | input | 3 | Status bits substituted into the channel B vector |
| fs_lo_i | input | 16 | Frame-status low byte, per channel |
| fs_hi_i | input | 16 | Frame-status high byte, per channel |
| tx_buf_o | output | 16 | Transmit buffers, per channel |
| tx_wr_o | output | 2 | One-cycle pulse when a transmit buffer is loaded |
| sync7_o | output | 16 | Register 7, per channel |
| sync7x_o | output | 16 | Extension register for address 7, per channel |
| int_ctl_o | output | 8 | Shared interrupt control register |

## Verification
Two things can happen on the same clock edge. A control write to register 15 changes the extension bit, and on that same edge the pointer is sent back to zero. The very next address-7 write must then follow the new value of the bit. The bench provokes this by clearing the bit and then, in the next pair of cycles, writing address 7. It judges the result by checking that `sync7_o` takes the byte while `sync7x_o` keeps its earlier value. A second case is a data access issued while the pointer is nonzero. It must load the buffer without disturbing the pending pointer, and the control read that follows confirms this.

// File: rtl/sio_reg_pkg.sv
// Package: shared constants and the read-address alias function.
// Assumes a 16-entry register map per channel and two channels.
package sio_reg_pkg;
    localparam int NCH   = 2;
    localparam int AW    = 4;
    localparam int NREG  = 1 << AW;

    localparam logic [AW-1:0] A_PTR   = 4'd0;
    localparam logic [AW-1:0] A_ST0   = 4'd0;
    localparam logic [AW-1:0] A_ST1   = 4'd1;
    localparam logic [AW-1:0] A_VEC   = 4'd2;
    localparam logic [AW-1:0] A_IP    = 4'd3;
    localparam logic [AW-1:0] A_FSLO  = 4'd6;
    localparam logic [AW-1:0] A_SYNC  = 4'd7;
    localparam logic [AW-1:0] A_FSHI  = 4'd7;
    localparam logic [AW-1:0] A_BUF   = 4'd8;
    localparam logic [AW-1:0] A_ICTL  = 4'd9;
    localparam logic [AW-1:0] A_ST10  = 4'd10;
    localparam logic [AW-1:0] A_TCLO  = 4'd12;
    localparam logic [AW-1:0] A_TCHI  = 4'd13;
    localparam logic [AW-1:0] A_MODE  = 4'd15;
    localparam logic [AW-1:0] A_ST15  = 4'd15;

    localparam logic [2:0] CMD_HIGH = 3'b001;

    // Map an unlisted read address onto the listed one it aliases.
    function automatic logic [AW-1:0] rd_alias(input logic [AW-1:0] a, input logic ext);
        logic [AW-1:0] r;
        case (a)
            4'd4:    r = A_ST0;
            4'd5:    r = A_ST1;
            4'd6:    r = ext ? A_FSLO : A_VEC;
            4'd7:    r = ext ? A_FSHI : A_IP;
            4'd9:    r = A_TCHI;
            4'd11:   r = A_ST15;
            4'd14:   r = A_ST10;
            default: r = a;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sio_ptr_ctl.sv
// Pointer for one channel. A control write at pointer 0 loads a new
// pointer; any control access at a nonzero pointer returns it to 0.
// Assumes acc_i is one cycle per access and already qualified by channel.
module sio_ptr_ctl
    import sio_reg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic          is_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [AW-1:0] ptr_o
);
    logic [AW-1:0] ptr_q;
    logic          hi_sel;

    // Decode the upper-half select from the command field.
    assign hi_sel = (wdata_i[5:3] == CMD_HIGH);

    // Load or clear the pointer on each control access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (acc_i) begin
            if (ptr_q == A_PTR && is_wr_i)
                ptr_q <= {hi_sel, wdata_i[2:0]};
            else
                ptr_q <= '0;
        end
    end

    assign ptr_o = ptr_q;

    p_ptr_home_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && ptr_q != A_PTR) |=> (ptr_o == A_PTR));

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(ptr_o));
endmodule

// File: rtl/sio_wr_bank.sv
// Write storage: per-channel registers, the extension register, the
// transmit buffers and the two shared registers.
// Assumes ctl_we_i/dat_we_i are mutually exclusive single-cycle strobes.
module sio_wr_bank
    import sio_reg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int EXT_BIT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ch_i,
    input  logic                    ctl_we_i,
    input  logic                    dat_we_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [DW-1:0]           vec_o,
    output logic [DW-1:0]           ictl_o,
    output logic [NCH-1:0]          ext_o,
    output logic [NCH-1:0][DW-1:0]  tclo_o,
    output logic [NCH-1:0][DW-1:0]  tchi_o,
    output logic [NCH-1:0][DW-1:0]  sync7_o,
    output logic [NCH-1:0][DW-1:0]  sync7x_o,
    output logic [NCH-1:0][DW-1:0]  tx_o,
    output logic [NCH-1:0]          txw_o
);
    logic [DW-1:0] vec_q, ictl_q;

    // Shared vector and interrupt control, written through either channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            ictl_q <= '0;
        end else if (ctl_we_i) begin
            if (addr_i == A_VEC)  vec_q  <= wdata_i;
            if (addr_i == A_ICTL) ictl_q <= wdata_i;
        end
    end

    assign vec_o  = vec_q;
    assign ictl_o = ictl_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] regs_q [NREG];
        logic [DW-1:0] x7_q, tx_q;
        logic          txw_q;
        logic          hit;

        assign hit = (ch_i == 1'(c));

        // Per-channel storage, transmit buffer and its load pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
                x7_q  <= '0;
                tx_q  <= '0;
                txw_q <= 1'b0;
            end else begin
                txw_q <= 1'b0;
                if (hit && dat_we_i) begin
                    tx_q  <= wdata_i;
                    txw_q <= 1'b1;
                end else if (hit && ctl_we_i) begin
                    case (addr_i)
                        A_PTR, A_VEC, A_ICTL: ;
                        A_BUF: begin
                            tx_q  <= wdata_i;
                            txw_q <= 1'b1;
                        end
                        A_SYNC: begin
                            if (regs_q[A_MODE][EXT_BIT]) x7_q <= wdata_i;
                            else                         regs_q[A_SYNC] <= wdata_i;
                        end
                        default: regs_q[addr_i] <= wdata_i;
                    endcase
                end
            end
        end

        assign ext_o[c]    = regs_q[A_MODE][EXT_BIT];
        assign tclo_o[c]   = regs_q[A_TCLO];
        assign tchi_o[c]   = regs_q[A_TCHI];
        assign sync7_o[c]  = regs_q[A_SYNC];
        assign sync7x_o[c] = x7_q;
        assign tx_o[c]     = tx_q;
        assign txw_o[c]    = txw_q;

        p_ext_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && ctl_we_i && addr_i == A_SYNC && ext_o[c]) |=> $stable(sync7_o[c]));
    end

    p_shared_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && addr_i == A_VEC) |=> (vec_o == $past(wdata_i)));

    p_txw_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(txw_o));
endmodule

// File: rtl/sio_rd_mux.sv
// Read path: aliases the pointer, then selects status, stored registers,
// frame status or the modified vector. Purely combinational.
// Assumes the caller gates the result with the read strobe.
module sio_rd_mux
    import sio_reg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int VEC_LSB = 1,
    parameter int VEC_W   = 3
) (
    input  logic                    ch_i,
    input  logic                    sel_data_i,
    input  logic [AW-1:0]           ptr_i,
    input  logic [NCH-1:0]          ext_i,
    input  logic [NCH-1:0][DW-1:0]  rx_i,
    input  logic [NCH-1:0][DW-1:0]  st0_i,
    input  logic [NCH-1:0][DW-1:0]  st1_i,
    input  logic [NCH-1:0][DW-1:0]  st10_i,
    input  logic [NCH-1:0][DW-1:0]  st15_i,
    input  logic [NCH-1:0][DW-1:0]  fslo_i,
    input  logic [NCH-1:0][DW-1:0]  fshi_i,
    input  logic [NCH-1:0][DW-1:0]  tclo_i,
    input  logic [NCH-1:0][DW-1:0]  tchi_i,
    input  logic [DW-1:0]           vec_i,
    input  logic [VEC_W-1:0]        vstat_i,
    input  logic [DW-1:0]           ip_i,
    output logic [DW-1:0]           rdata_o
);
    logic [AW-1:0] eff;
    logic [DW-1:0] vec_mod;

    // Channel B vector carries status in the substitution field.
    always_comb begin
        vec_mod = vec_i;
        vec_mod[VEC_LSB +: VEC_W] = vstat_i;
    end

    assign eff = rd_alias(ptr_i, ext_i[ch_i]);

    // Select the byte for the effective address.
    always_comb begin
        if (sel_data_i) begin
            rdata_o = rx_i[ch_i];
        end else begin
            case (eff)
                A_ST0:   rdata_o = st0_i[ch_i];
                A_ST1:   rdata_o = st1_i[ch_i];
                A_VEC:   rdata_o = ch_i ? vec_mod : vec_i;
                A_IP:    rdata_o = ch_i ? '0 : ip_i;
                A_FSLO:  rdata_o = fslo_i[ch_i];
                A_FSHI:  rdata_o = fshi_i[ch_i];
                A_BUF:   rdata_o = rx_i[ch_i];
                A_ST10:  rdata_o = st10_i[ch_i];
                A_TCLO:  rdata_o = tclo_i[ch_i];
                A_TCHI:  rdata_o = tchi_i[ch_i];
                A_ST15:  rdata_o = st15_i[ch_i];
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/sio_regfile_top.sv
// Top: host bus decode, two channel pointers, write bank and read mux.
// Assumes one access per strobe cycle; if both strobes are high the
// access counts as a write for the pointer.
module sio_regfile_top
    import sio_reg_pkg::*;
#(
    parameter int DW      = 8,
    parameter int EXT_BIT = 0,
    parameter int VEC_LSB = 1,
    parameter int VEC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_data,
    input  logic              chan_b,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [2*DW-1:0]   rx_data_i,
    input  logic [2*DW-1:0]   st0_i,
    input  logic [2*DW-1:0]   st1_i,
    input  logic [2*DW-1:0]   st10_i,
    input  logic [2*DW-1:0]   st15_i,
    input  logic [DW-1:0]     ip_i,
    input  logic [VEC_W-1:0]  vstat_i,
    input  logic [2*DW-1:0]   fs_lo_i,
    input  logic [2*DW-1:0]   fs_hi_i,
    output logic [2*DW-1:0]   tx_buf_o,
    output logic [NCH-1:0]    tx_wr_o,
    output logic [2*DW-1:0]   sync7_o,
    output logic [2*DW-1:0]   sync7x_o,
    output logic [DW-1:0]     int_ctl_o
);
    logic [NCH-1:0][AW-1:0] ptr_w;
    logic [NCH-1:0]         ext_w;
    logic [NCH-1:0][DW-1:0] tclo_w, tchi_w, s7_w, s7x_w, tx_w;
    logic [DW-1:0]          vec_w, rd_w;
    logic                   ctl_we, dat_we;

    // Qualify bus strobes by access kind.
    assign ctl_we = wr_stb && !sel_data;
    assign dat_we = wr_stb &&  sel_data;

    for (genvar c = 0; c < NCH; c++) begin : g_ptr
        sio_ptr_ctl #(.DW(DW)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_i   (!sel_data && (wr_stb || rd_stb) && (chan_b == 1'(c))),
            .is_wr_i (wr_stb),
            .wdata_i (wdata),
            .ptr_o   (ptr_w[c])
        );
    end

    sio_wr_bank #(.DW(DW), .EXT_BIT(EXT_BIT)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_i     (chan_b),
        .ctl_we_i (ctl_we),
        .dat_we_i (dat_we),
        .addr_i   (ptr_w[chan_b]),
        .wdata_i  (wdata),
        .vec_o    (vec_w),
        .ictl_o   (int_ctl_o),
        .ext_o    (ext_w),
        .tclo_o   (tclo_w),
        .tchi_o   (tchi_w),
        .sync7_o  (s7_w),
        .sync7x_o (s7x_w),
        .tx_o     (tx_w),
        .txw_o    (tx_wr_o)
    );

    sio_rd_mux #(.DW(DW), .VEC_LSB(VEC_LSB), .VEC_W(VEC_W)) u_rd (
        .ch_i       (chan_b),
        .sel_data_i (sel_data),
        .ptr_i      (ptr_w[chan_b]),
        .ext_i      (ext_w),
        .rx_i       (rx_data_i),
        .st0_i      (st0_i),
        .st1_i      (st1_i),
        .st10_i     (st10_i),
        .st15_i     (st15_i),
        .fslo_i     (fs_lo_i),
        .fshi_i     (fs_hi_i),
        .tclo_i     (tclo_w),
        .tchi_i     (tchi_w),
        .vec_i      (vec_w),
        .vstat_i    (vstat_i),
        .ip_i       (ip_i),
        .rdata_o    (rd_w)
    );

    // Drive read data only during a read strobe.
    assign rdata    = rd_stb ? rd_w : '0;
    assign tx_buf_o = tx_w;
    assign sync7_o  = s7_w;
    assign sync7x_o = s7x_w;

    p_ip_chb_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && !sel_data && chan_b && ptr_w[1] == A_IP) |-> (rdata == '0));

    p_data_ptr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_data && (wr_stb || rd_stb)) |=> $stable(ptr_w));
endmodule

// File: tb/tb_sio_regfile_top.sv
module tb_sio_regfile_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_data = 1'b0, chan_b = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] rx_data_i = 16'hA55A, st0_i = 16'h2111, st1_i = 16'h2212;
    logic [15:0] st10_i = 16'h2313, st15_i = 16'h2414;
    logic [7:0]  ip_i = 8'hC3;
    logic [2:0]  vstat_i = 3'b101;
    logic [15:0] fs_lo_i = 16'h4131, fs_hi_i = 16'h4232;
    logic [15:0] tx_buf_o, sync7_o, sync7x_o;
    logic [1:0]  tx_wr_o;
    logic [7:0]  int_ctl_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    sio_regfile_top dut (
        .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .chan_b(chan_b),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata),
        .rx_data_i(rx_data_i), .st0_i(st0_i), .st1_i(st1_i), .st10_i(st10_i),
        .st15_i(st15_i), .ip_i(ip_i), .vstat_i(vstat_i), .fs_lo_i(fs_lo_i),
        .fs_hi_i(fs_hi_i), .tx_buf_o(tx_buf_o), .tx_wr_o(tx_wr_o),
        .sync7_o(sync7_o), .sync7x_o(sync7x_o), .int_ctl_o(int_ctl_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input bit d, input bit ch, input logic [7:0] v);
        @(negedge clk);
        sel_data = d; chan_b = ch; wdata = v; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input bit d, input bit ch, output logic [7:0] v);
        @(negedge clk);
        sel_data = d; chan_b = ch; rd_stb = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Pointer byte equals the address: code 001 in [5:3] for 8..15.
    task automatic ctl_write(input bit ch, input logic [3:0] a, input logic [7:0] v);
        if (a != 0) bus_wr(1'b0, ch, {4'h0, a});
        bus_wr(1'b0, ch, v);
    endtask

    task automatic ctl_read(input bit ch, input logic [3:0] a, output logic [7:0] v);
        if (a != 0) bus_wr(1'b0, ch, {4'h0, a});
        bus_rd(1'b0, ch, v);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 tx_buf", tx_buf_o, 16'h0);
        check("R1 tx_wr", {14'h0, tx_wr_o}, 16'h0);
        check("R1 sync7", sync7_o, 16'h0);
        check("R1 sync7x", sync7x_o, 16'h0);
        check("R1 int_ctl", {8'h0, int_ctl_o}, 16'h0);
        ctl_read(1'b0, 4'd12, v); check("R1 RR12 A", {8'h0, v}, 16'h0);
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        ctl_write(1'b0, 4'd12, 8'h34);
        ctl_write(1'b0, 4'd13, 8'h12);
        ctl_read(1'b0, 4'd12, v); check("R2 RR12 A", {8'h0, v}, 16'h0034);
        ctl_read(1'b0, 4'd13, v); check("R2 RR13 A", {8'h0, v}, 16'h0012);
        // Code 010 in [5:3] is not point-high: 8'h14 selects address 4 (alias of 0).
        bus_wr(1'b0, 1'b0, 8'h14);
        bus_rd(1'b0, 1'b0, v); check("R2 no-high code", {8'h0, v}, 16'h0011);
        ctl_read(1'b0, 4'd1, v); check("R3 RR1 A", {8'h0, v}, 16'h0012);
        bus_rd(1'b0, 1'b0, v); check("R3 ptr home read", {8'h0, v}, 16'h0011);
    endtask

    task automatic t_channels;
        logic [7:0] v;
        ctl_write(1'b1, 4'd12, 8'h77);
        bus_wr(1'b0, 1'b0, 8'h0C);            // A pointer -> 12
        ctl_write(1'b1, 4'd13, 8'h99);        // B traffic in between
        bus_rd(1'b0, 1'b0, v); check("R5 A ptr kept", {8'h0, v}, 16'h0034);
        ctl_read(1'b1, 4'd12, v); check("R5 RR12 B", {8'h0, v}, 16'h0077);
        ctl_read(1'b1, 4'd13, v); check("R5 RR13 B", {8'h0, v}, 16'h0099);
        ctl_read(1'b0, 4'd13, v); check("R5 RR13 A", {8'h0, v}, 16'h0012);
    endtask

    task automatic t_data;
        logic [7:0] v;
        bus_wr(1'b1, 1'b0, 8'hE1);
        check("R4 tx A", tx_buf_o, 16'h00E1);
        check("R4 tx_wr A", {14'h0, tx_wr_o}, 16'h0001);
        @(negedge clk); check("R4 tx_wr pulse end", {14'h0, tx_wr_o}, 16'h0000);
        bus_wr(1'b0, 1'b1, 8'h0C);            // B pointer -> 12
        bus_wr(1'b1, 1'b1, 8'hB2);
        check("R4 tx B", tx_buf_o, 16'hB2E1);
        bus_rd(1'b1, 1'b1, v); check("R4 data read B", {8'h0, v}, 16'h00A5);
        bus_rd(1'b0, 1'b1, v); check("R4 ptr kept by data", {8'h0, v}, 16'h0077);
        bus_rd(1'b1, 1'b0, v); check("R4 data read A", {8'h0, v}, 16'h005A);
        ctl_write(1'b0, 4'd8, 8'hC7);
        check("R4 ctl addr8 tx A", tx_buf_o, 16'hB2C7);
    endtask

    task automatic t_shared;
        logic [7:0] v;
        ctl_write(1'b1, 4'd9, 8'h3C);
        check("R6 int_ctl via B", {8'h0, int_ctl_o}, 16'h003C);
        ctl_write(1'b0, 4'd9, 8'h5D);
        check("R6 int_ctl via A", {8'h0, int_ctl_o}, 16'h005D);
        ctl_write(1'b0, 4'd2, 8'h80);
        ctl_read(1'b0, 4'd2, v); check("R9 RR2 A plain", {8'h0, v}, 16'h0080);
        ctl_read(1'b1, 4'd2, v); check("R9 RR2 B modified", {8'h0, v}, 16'h008A);
        ctl_write(1'b1, 4'd2, 8'hF0);
        ctl_read(1'b0, 4'd2, v); check("R6 vec via B seen on A", {8'h0, v}, 16'h00F0);
    endtask

    task automatic t_status;
        logic [7:0] v;
        ctl_read(1'b0, 4'd3, v);  check("R10 RR3 A", {8'h0, v}, 16'h00C3);
        ctl_read(1'b1, 4'd3, v);  check("R10 RR3 B", {8'h0, v}, 16'h0000);
        ctl_read(1'b1, 4'd0, v);  check("R11 RR0 B", {8'h0, v}, 16'h0021);
        ctl_read(1'b1, 4'd1, v);  check("R11 RR1 B", {8'h0, v}, 16'h0022);
        ctl_read(1'b0, 4'd10, v); check("R11 RR10 A", {8'h0, v}, 16'h0013);
        ctl_read(1'b1, 4'd15, v); check("R11 RR15 B", {8'h0, v}, 16'h0024);
        ctl_read(1'b1, 4'd4, v);  check("R12 RR4->0", {8'h0, v}, 16'h0021);
        ctl_read(1'b0, 4'd5, v);  check("R12 RR5->1", {8'h0, v}, 16'h0012);
        ctl_read(1'b0, 4'd9, v);  check("R12 RR9->13", {8'h0, v}, 16'h0012);
        ctl_read(1'b0, 4'd11, v); check("R12 RR11->15", {8'h0, v}, 16'h0014);
        ctl_read(1'b1, 4'd14, v); check("R12 RR14->10", {8'h0, v}, 16'h0023);
        ctl_read(1'b1, 4'd8, v);  check("R12 RR8 rx", {8'h0, v}, 16'h00A5);
    endtask

    task automatic t_ext;
        logic [7:0] v;
        ctl_read(1'b0, 4'd6, v); check("R8 RR6 A off", {8'h0, v}, 16'h00F0);
        ctl_read(1'b0, 4'd7, v); check("R8 RR7 A off", {8'h0, v}, 16'h00C3);
        ctl_write(1'b0, 4'd7, 8'h7E);
        check("R7 WR7 A", sync7_o, 16'h007E);
        ctl_write(1'b0, 4'd15, 8'h01);
        ctl_write(1'b0, 4'd7, 8'h44);
        check("R7 ext A", sync7x_o, 16'h0044);
        check("R7 WR7 A untouched", sync7_o, 16'h007E);
        ctl_read(1'b0, 4'd6, v); check("R8 RR6 A on", {8'h0, v}, 16'h0031);
        ctl_read(1'b0, 4'd7, v); check("R8 RR7 A on", {8'h0, v}, 16'h0032);
        ctl_read(1'b1, 4'd6, v); check("R8 RR6 B off", {8'h0, v}, 16'h00FA);
        ctl_read(1'b1, 4'd7, v); check("R8 RR7 B off", {8'h0, v}, 16'h0000);
        ctl_write(1'b1, 4'd7, 8'h66);
        check("R7 WR7 B", sync7_o, 16'h667E);
        // Clear the bit and hit address 7 right after.
        ctl_write(1'b0, 4'd15, 8'h00);
        ctl_write(1'b0, 4'd7, 8'h19);
        check("R7 WR7 A after clear", sync7_o, 16'h6619);
        check("R7 ext A kept", sync7x_o, 16'h0044);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_channels();
        t_data();
        t_shared();
        t_status();
        t_ext();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule